// File: doc/BRIEF.md
# Pulse-Driven Receive Latch with Stall Default

This block is the receiving half of a channel that carries one logic level across a barrier as a stream of edge pulses. A set pulse drives the recovered bit high and a reset pulse drives it low. Between pulses the bit is held in a bistable latch. The sending side keeps issuing refresh pulses even when its input is static, so a live link never goes quiet for long.

A watchdog counts clock cycles since the last received pulse. If the stream goes quiet for `TIMEOUT_CYC` cycles, the sender is treated as unpowered or disabled. The output is then forced to a fallback level picked by a control input, and a flag reports that the fallback is in force. The first pulse that arrives afterwards clears the flag and hands the output back to the latch. The control input is expected to have a pull-up at the pad, so an unconnected pin reaches the block as a 1.

Top module: `iso_rx_decoder`

## Requirements
- R1: A cycle with `set_pulse`=1 and `clr_pulse`=0 makes `data_out`=1 and `dflt_active`=0 after that clock edge.
- R2: A cycle with `clr_pulse`=1 and `set_pulse`=0 makes `data_out`=0 and `dflt_active`=0 after that clock edge.
- R3: In cycles with no pulse and before a timeout, `data_out` keeps the value left by the last pulse.
- R4: A cycle with both `set_pulse` and `clr_pulse` at 1 leaves the latched bit unchanged. It still counts as a received pulse, so it clears the watchdog and ends any fallback.
- R5: After a pulse edge followed by `TIMEOUT_CYC` consecutive clock edges with no pulse, `dflt_active` becomes 1 at the last of those edges.
- R6: While `dflt_active`=1, `data_out` equals `dflt_sel`: 1 selects a high fallback and 0 a low one. The output follows `dflt_sel` within the same cycle.
- R7: While `dflt_active`=0, `dflt_sel` has no effect on `data_out`.
- R8: When a pulse arrives while `dflt_active`=1, the next edge clears `dflt_active` and `data_out` shows the latch as updated by that pulse.
- R9: A clock edge with `rst_n`=0 clears the latch to 0 and sets `dflt_active`=1, so `data_out` equals `dflt_sel` until the first pulse.
- R10: A pulse at the edge `TIMEOUT_CYC` after the previous pulse, just before expiry, restarts the count and prevents the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_pulse | input | 1 | One-cycle pulse that sets the recovered bit |
| clr_pulse | input | 1 | One-cycle pulse that clears the recovered bit |
| dflt_sel | input | 1 | Fallback level used while the stream is stalled (pad pull-up gives 1 when open) |
| data_out | output | 1 | Recovered data bit, or the fallback level during a stall |
| dflt_active | output | 1 | 1 while the fallback level is driving `data_out` |

## Verification
The bench places pulses exactly one edge before the timeout and exactly at it. An off-by-one counter would show up there as a fallback that comes early, or as a fallback that never comes. It sends coincident set and reset pulses, both while the link is live and as the first pulse after a stall. A design that gave one of the two priority would flip the bit, and a design that ignored the coincident pulse would leave the fallback in force. It toggles `dflt_sel` both while the link is live and while the fallback is in force. A leaky output mux would pass the control level through on a live link, or would freeze a stale fallback level during a stall.

// File: rtl/iso_rx_pkg.sv
// Package: shared types for the pulse-driven receive latch.
// Assumes set and reset pulses are already synchronous to the receive clock.
package iso_rx_pkg;

    // Command decoded from the two pulse lines in one cycle.
    typedef enum logic [1:0] {
        CMD_IDLE     = 2'b00,
        CMD_SET      = 2'b01,
        CMD_CLR      = 2'b10,
        CMD_CONFLICT = 2'b11
    } rx_cmd_e;

    // Map the pulse pair onto a command.
    function automatic rx_cmd_e decode_cmd(input logic set_p, input logic clr_p);
        return rx_cmd_e'({clr_p, set_p});
    endfunction

    // True for any received pulse, including a conflict.
    function automatic logic cmd_is_pulse(input rx_cmd_e cmd);
        return cmd != CMD_IDLE;
    endfunction

endpackage

// File: rtl/iso_rx_cmd_latch.sv
// Bistable holding the recovered bit.
// SET drives 1, CLR drives 0, IDLE and CONFLICT hold. Synchronous active-low reset to 0.
module iso_rx_cmd_latch
    import iso_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rx_cmd_e cmd,
    output logic    q
);

    logic q_nxt;

    // Next-state selection from the decoded command.
    always_comb begin
        unique case (cmd)
            CMD_SET: q_nxt = 1'b1;
            CMD_CLR: q_nxt = 1'b0;
            default: q_nxt = q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/iso_rx_watchdog.sv
// Stall watchdog: counts idle edges since the last pulse and raises
// `expired` at the TIMEOUT_CYC-th idle edge. Any pulse clears it.
// The count stops while expired. Reset leaves the watchdog expired.
module iso_rx_watchdog #(
    parameter int TIMEOUT_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_seen,
    output logic expired
);

    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] idle_cnt;

    // Idle-edge counter and expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            expired  <= 1'b1;
        end else if (pulse_seen) begin
            idle_cnt <= '0;
            expired  <= 1'b0;
        end else if (!expired) begin
            if (idle_cnt == LAST_IDLE) begin
                expired <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iso_rx_decoder.sv
// Receive-side decoder: a pulse-driven latch plus a stall watchdog.
// While the watchdog is expired the output shows dflt_sel, otherwise the latch.
// Assumes dflt_sel has a pull-up at the pad, so an open pin arrives as 1.
module iso_rx_decoder
    import iso_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    input  logic dflt_sel,
    output logic data_out,
    output logic dflt_active
);

    rx_cmd_e cmd;
    logic    latch_q;
    logic    stalled;

    // Decode the pulse pair once for both consumers.
    always_comb cmd = decode_cmd(set_pulse, clr_pulse);

    iso_rx_cmd_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .q     (latch_q)
    );

    iso_rx_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_seen (cmd_is_pulse(cmd)),
        .expired    (stalled)
    );

    // Output select: fallback level during a stall, latched bit otherwise.
    always_comb begin
        dflt_active = stalled;
        data_out    = stalled ? dflt_sel : latch_q;
    end

endmodule

// File: rtl/iso_rx_decoder_chk.sv
// Checker for iso_rx_decoder, observing ports only; bound below.
// Keeps its own idle-edge count so the timeout window is not unrolled.
module iso_rx_decoder_chk #(
    parameter int TIMEOUT_CYC = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic set_pulse,
    input logic clr_pulse,
    input logic dflt_sel,
    input logic data_out,
    input logic dflt_active
);

    localparam int QW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [QW-1:0] Q_MAX = QW'(TIMEOUT_CYC);

    logic [QW-1:0] quiet;
    logic          any_p;

    // A conflict counts as a pulse.
    always_comb any_p = set_pulse | clr_pulse;

    // Saturating count of idle edges since the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          quiet <= '0;
        else if (any_p)      quiet <= '0;
        else if (quiet != Q_MAX) quiet <= quiet + 1'b1;
    end

    assert_set_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse && !clr_pulse) |=> (data_out && !dflt_active));

    assert_clr_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !set_pulse) |=> (!data_out && !dflt_active));

    assert_conflict_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse && clr_pulse && !dflt_active) |=> (data_out == $past(data_out) && !dflt_active));

    assert_timeout_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_p && !dflt_active && quiet == QW'(TIMEOUT_CYC - 1)) |=> dflt_active);

    assert_no_early_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_p && !dflt_active && quiet < QW'(TIMEOUT_CYC - 1)) |=> !dflt_active);

    assert_fallback_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_active |-> (data_out == dflt_sel));

    assert_pulse_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_p && dflt_active) |=> !dflt_active);

endmodule

bind iso_rx_decoder iso_rx_decoder_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_pulse   (set_pulse),
    .clr_pulse   (clr_pulse),
    .dflt_sel    (dflt_sel),
    .data_out    (data_out),
    .dflt_active (dflt_active)
);

// File: tb/iso_rx_decoder_tb_top.sv
// Scoreboard bench: the driver task applies one cycle of stimulus, runs a
// behavioural model built from the requirements, and queues the expected
// outputs. The monitor pops and compares one item per cycle after each edge.
module iso_rx_decoder_tb_top;

    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_pulse = 1'b0;
    logic clr_pulse = 1'b0;
    logic dflt_sel = 1'b1;
    logic data_out;
    logic dflt_active;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Reference model state.
    logic m_latch = 1'b0;
    int   m_idle = 0;
    logic m_stall = 1'b1;

    always #2 clk = ~clk;

    iso_rx_decoder #(.TIMEOUT_CYC(TO)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pulse   (set_pulse),
        .clr_pulse   (clr_pulse),
        .dflt_sel    (dflt_sel),
        .data_out    (data_out),
        .dflt_active (dflt_active)
    );

    // Driver: one cycle of stimulus plus the model's expected result.
    task automatic step(input logic rst, input logic s, input logic c,
                        input logic sel, input string tag);
        @(negedge clk);
        rst_n = rst; set_pulse = s; clr_pulse = c; dflt_sel = sel;
        if (!rst) begin
            m_latch = 1'b0; m_idle = 0; m_stall = 1'b1;
        end else if (s || c) begin
            if (s && !c) m_latch = 1'b1;
            if (c && !s) m_latch = 1'b0;
            m_idle = 0; m_stall = 1'b0;
        end else if (!m_stall) begin
            m_idle++;
            if (m_idle == TO) m_stall = 1'b1;
        end
        exp_q.push_back({m_stall ? sel : m_latch, m_stall});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input logic sel, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, sel, tag);
    endtask

    // Monitor: compare after each edge, once outputs have settled.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({data_out, dflt_active} !== e) begin
                    errors++;
                    $display("FAIL %s: data_out/dflt_active actual=%b%b expected=%b%b",
                             t, data_out, dflt_active, e[1], e[0]);
                end
            end
        end
    end

    // Stimulus.
    initial begin
        step(1'b0, 1'b0, 1'b0, 1'b1, "R9 reset high fallback");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R9 reset ignores pulse");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R9 after reset");
        idle(2, 1'b0, "R9 low fallback before first pulse");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1 set after reset R8");
        idle(3, 1'b0, "R3 hold high R7 sel low");
        idle(3, 1'b1, "R7 sel high no effect");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R2 clear");
        idle(2, 1'b1, "R3 hold low R7");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R4 conflict holds low");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1 set");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R4 conflict holds high");
        idle(TO - 1, 1'b0, "R10 window before expiry");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R10 pulse at last edge");
        idle(TO - 1, 1'b1, "R10 restarted window");
        idle(1, 1'b1, "R5 expiry edge high fallback");
        idle(2, 1'b0, "R6 fallback follows sel low");
        idle(2, 1'b1, "R6 fallback follows sel high");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8 set restores");
        idle(TO, 1'b0, "R5 second timeout low");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R4 R8 conflict ends stall");
        idle(2, 1'b0, "R3 hold after conflict restore");
        idle(TO + 2, 1'b1, "R5 third timeout");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R8 clear restores");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R3 hold low");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog for the bench itself.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule